// File: doc/BRIEF.md
# DRAM refresh and initialisation scheduler

This block takes an asynchronous DRAM bank from power-up to steady operation and keeps it refreshed. It holds the bank idle for the start-up pause after reset. It then runs a fixed number of wake-up refresh cycles one after another. From then on it runs CAS-before-RAS refresh cycles at a programmable rate. The RAS and CAS strobes are shared with the access sequencer, so the block asks for the strobe bus and drives the strobes only while the bus is granted. The init_done output tells the host side when accesses may begin.

Every analogue timing limit is a parameter in nanoseconds. It is turned into a whole number of clock cycles, rounded up, from the clock period parameter. The interval timer runs only after initialisation. Each time it expires it adds one refresh to a small saturating backlog, so a late grant delays refreshes but does not lose them, up to the backlog depth.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, ras_n, cas_n and we_n are 1, and bus_req, strobe_en and init_done are 0.
- R2: bus_req stays 0 for at least ceil(T_PAUSE_NS / clock period) cycles after reset is released (5000 cycles at the defaults), and it rises within a few cycles after that.
- R3: After the pause, exactly INIT_CYCLES (8 at the defaults) CAS-before-RAS cycles are issued back to back, without waiting for the interval timer, before init_done rises.
- R4: init_done is 0 when the last wake-up cycle's RAS falls. It rises after that cycle's precharge and then stays 1 until reset.
- R5: In every cycle, cas_n goes to 0 at least ceil(T_CSR_NS) cycles before ras_n falls (1 at the defaults) and stays 0 for the whole time ras_n is 0. we_n is always 1.
- R6: ras_n stays 0 for at least 3 cycles and is 1 for at least 2 cycles before each fall. Consecutive RAS falls are at least 5 cycles apart. These are the default-parameter roundings of the pulse width, precharge and cycle-time limits.
- R7: After init_done, one refresh cycle is issued every interval_cycles clock cycles when the grant is immediate. A new interval value takes effect at the next expiry of the timer.
- R8: Timer expiries that arrive while the grant is withheld are kept. bus_req stays 1 while waiting, and the kept refreshes are issued back to back once the grant arrives.
- R9: The backlog saturates at MAX_BACKLOG (4 at the defaults). Expiries beyond that are dropped, so at most 4 refreshes (plus any expiry during the burst) follow a long withheld grant.
- R10: ras_n or cas_n low, or strobe_en high, happens only while bus_gnt is 1. bus_req stays 1 from the request until that cycle's precharge ends.
- R11: A timer expiry and the completion of a refresh cycle in the same clock cycle are both counted. With the interval equal to the cycle length, the refresh rate equals the expiry rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also marks power-up |
| interval_cycles | input | IW | Refresh interval in clock cycles, used at each timer expiry |
| bus_gnt | input | 1 | Strobe bus granted to this block |
| bus_req | output | 1 | Request for the strobe bus |
| strobe_en | output | 1 | This block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Wake-up sequence complete, host access allowed |

## Verification
The two functions that can fall in the same cycle are a timer expiry, which increments the backlog, and the completion of a refresh cycle, which decrements it. They also meet when an expiry hits a full backlog while a burst is draining. The bench sets interval_cycles to exactly the length of one refresh cycle with the grant always given, so the two events line up repeatedly. It judges the result by counting RAS falls over a 1000-cycle window against the expected 100. The saturation case is driven by withholding the grant for six intervals and checking that the released burst holds no more than the backlog depth.

// File: rtl/drs_pkg.sv
// Package: shared state types and the time-to-cycle conversion used by the
// refresh scheduler. Assumes times in ns and a clock period in ps.
package drs_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_REQ,
        ENG_PRE,
        ENG_CSR,
        ENG_RAS,
        ENG_POST
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_t;

    // Round a time in ns up to whole clock cycles, never less than one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (t_ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two cycle counts.
    function automatic int unsigned cmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Remaining cycles after a part already spent, never less than zero.
    function automatic int unsigned csub(input int unsigned a, input int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

endpackage

// File: rtl/drs_interval_timer.sv
// Interval timer: once enabled, it pulses tick every interval_cycles cycles.
// The limit is compared with >= so that a lowered interval takes effect at the
// next expiry. Assumes interval_cycles of 0 means 1.
module drs_interval_timer #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [IW-1:0] interval_cycles,
    output logic          tick
);
    logic [IW-1:0] cnt_q;
    logic [IW-1:0] limit;

    // Last count value of an interval.
    always_comb begin
        limit = (interval_cycles == '0) ? '0 : interval_cycles - 1'b1;
        tick  = en && (cnt_q >= limit);
    end

    // Interval counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/drs_backlog.sv
// Backlog counter of refreshes that are owed. Timer ticks add to it and
// completed cycles take from it. A tick is kept when the counter is full only
// if a completion frees a slot in the same cycle.
module drs_backlog #(
    parameter int MAX_BACKLOG = 4,
    localparam int BW = $clog2(MAX_BACKLOG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dec,
    output logic pending
);
    localparam logic [BW-1:0] FULL = BW'(MAX_BACKLOG);

    logic [BW-1:0] cnt_q;
    logic          take_inc;
    logic          take_dec;

    // Decide which events apply this cycle.
    always_comb begin
        take_dec = dec && (cnt_q != '0);
        take_inc = tick && ((cnt_q != FULL) || take_dec);
        pending  = (cnt_q != '0);
    end

    // Saturating owed-refresh count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({take_inc, take_dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/drs_init_seq.sv
// Power-up sequencer: counts out the start-up pause, then asks for
// INIT_CYCLES refresh cycles and raises init_done after the last one
// completes. Assumes INIT_CYCLES >= 1 and PAUSE_CYC >= 1.
module drs_init_seq
    import drs_pkg::*;
#(
    parameter int PAUSE_CYC   = 5000,
    parameter int INIT_CYCLES = 8,
    localparam int PW = $clog2(PAUSE_CYC + 1),
    localparam int LW = $clog2(INIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_done,
    output logic want_init,
    output logic init_done
);
    phase_t        phase_q;
    logic [PW-1:0] pause_q;
    logic [LW-1:0] left_q;

    // Request wake-up cycles only in the init phase.
    always_comb begin
        want_init = (phase_q == PH_INIT);
    end

    // Phase progression from pause through init to run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_PAUSE;
            pause_q   <= '0;
            left_q    <= '0;
            init_done <= 1'b0;
        end else begin
            case (phase_q)
                PH_PAUSE: begin
                    if (pause_q == PW'(PAUSE_CYC - 1)) begin
                        phase_q <= PH_INIT;
                        left_q  <= LW'(INIT_CYCLES);
                    end else begin
                        pause_q <= pause_q + 1'b1;
                    end
                end
                PH_INIT: begin
                    if (cycle_done) begin
                        if (left_q == LW'(1)) begin
                            phase_q   <= PH_RUN;
                            init_done <= 1'b1;
                        end
                        left_q <= left_q - 1'b1;
                    end
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

endmodule

// File: rtl/drs_cbr_engine.sv
// CAS-before-RAS cycle engine: on want it requests the bus and waits for the
// grant. It precharges with both strobes high, drops CAS, then RAS, holds RAS
// low, then raises both and precharges again before releasing the bus.
// Strobe outputs are registered. Assumes the grant is not withdrawn while
// bus_req is high. Each phase length is at least one cycle.
module drs_cbr_engine
    import drs_pkg::*;
#(
    parameter int C_PRE  = 2,
    parameter int C_CSR  = 1,
    parameter int C_RAS  = 3,
    parameter int C_POST = 2,
    localparam int CMAXV = (C_PRE > C_CSR ? C_PRE : C_CSR) > (C_RAS > C_POST ? C_RAS : C_POST)
                         ? (C_PRE > C_CSR ? C_PRE : C_CSR) : (C_RAS > C_POST ? C_RAS : C_POST),
    localparam int CW = $clog2(CMAXV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic bus_gnt,
    output logic bus_req,
    output logic strobe_en,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    eng_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next state and phase counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done    = 1'b0;
        case (state_q)
            ENG_IDLE: if (want) state_d = ENG_REQ;
            ENG_REQ: begin
                if (bus_gnt) begin
                    state_d = ENG_PRE;
                    cnt_d   = CW'(C_PRE - 1);
                end
            end
            ENG_PRE: begin
                if (cnt_q == '0) begin
                    state_d = ENG_CSR;
                    cnt_d   = CW'(C_CSR - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ENG_CSR: begin
                if (cnt_q == '0) begin
                    state_d = ENG_RAS;
                    cnt_d   = CW'(C_RAS - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ENG_RAS: begin
                if (cnt_q == '0) begin
                    state_d = ENG_POST;
                    cnt_d   = CW'(C_POST - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ENG_POST: begin
                if (cnt_q == '0) begin
                    state_d = ENG_IDLE;
                    done    = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ENG_IDLE;
        endcase
    end

    // State register and registered strobe decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ENG_IDLE;
            cnt_q     <= '0;
            bus_req   <= 1'b0;
            strobe_en <= 1'b0;
            ras_n     <= 1'b1;
            cas_n     <= 1'b1;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            bus_req   <= (state_d != ENG_IDLE);
            strobe_en <= (state_d != ENG_IDLE) && (state_d != ENG_REQ);
            ras_n     <= (state_d != ENG_RAS);
            cas_n     <= !((state_d == ENG_CSR) || (state_d == ENG_RAS));
        end
    end

endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the refresh scheduler: converts the ns timing parameters into cycle
// counts (rounded up) and ties together the power-up sequencer, the interval
// timer, the backlog and the cycle engine. Assumes bus_gnt answers bus_req and
// stays high until bus_req falls.
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int T_PAUSE_NS    = 100000,
    parameter int INIT_CYCLES   = 8,
    parameter int T_RAS_NS      = 50,
    parameter int T_RP_NS       = 30,
    parameter int T_RC_NS       = 84,
    parameter int T_CSR_NS      = 12,
    parameter int T_CHR_NS      = 8,
    parameter int T_RPC_NS      = 5,
    parameter int T_WRP_NS      = 12,
    parameter int MAX_BACKLOG   = 4,
    parameter int IW            = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval_cycles,
    input  logic          bus_gnt,
    output logic          bus_req,
    output logic          strobe_en,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          init_done
);
    localparam int PAUSE_CYC = ns_to_cycles(T_PAUSE_NS, CLK_PERIOD_PS);
    localparam int C_CSR     = ns_to_cycles(T_CSR_NS, CLK_PERIOD_PS);
    localparam int C_RAS     = cmax(ns_to_cycles(T_RAS_NS, CLK_PERIOD_PS),
                                    ns_to_cycles(T_CHR_NS, CLK_PERIOD_PS));
    localparam int C_RP      = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int C_POST    = cmax(C_RP, csub(ns_to_cycles(T_RC_NS, CLK_PERIOD_PS), C_RAS));
    localparam int C_PRE     = cmax(cmax(C_RP, ns_to_cycles(T_RPC_NS, CLK_PERIOD_PS)),
                                    csub(ns_to_cycles(T_WRP_NS, CLK_PERIOD_PS), C_CSR));

    logic want_init;
    logic tick;
    logic pending;
    logic cycle_done;
    logic want;

    // Combine the wake-up request with owed refreshes once running.
    always_comb begin
        want = want_init || (init_done && pending);
        we_n = 1'b1;
    end

    drs_init_seq #(
        .PAUSE_CYC  (PAUSE_CYC),
        .INIT_CYCLES(INIT_CYCLES)
    ) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_done(cycle_done),
        .want_init (want_init),
        .init_done (init_done)
    );

    drs_interval_timer #(
        .IW(IW)
    ) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (init_done),
        .interval_cycles(interval_cycles),
        .tick           (tick)
    );

    drs_backlog #(
        .MAX_BACKLOG(MAX_BACKLOG)
    ) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .dec    (cycle_done && init_done),
        .pending(pending)
    );

    drs_cbr_engine #(
        .C_PRE (C_PRE),
        .C_CSR (C_CSR),
        .C_RAS (C_RAS),
        .C_POST(C_POST)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .bus_gnt  (bus_gnt),
        .bus_req  (bus_req),
        .strobe_en(strobe_en),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .done     (cycle_done)
    );

endmodule

// File: rtl/drs_checker.sv
// Checker for the refresh scheduler: the strobe protocol, the pause and the
// init_done behaviour, watched at the top-level ports.
module drs_checker #(
    parameter int PAUSE_CYC = 5000,
    parameter int RAS_CYC   = 3,
    parameter int PRE_CYC   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bus_gnt,
    input logic bus_req,
    input logic strobe_en,
    input logic ras_n,
    input logic cas_n,
    input logic init_done
);
    logic [31:0] since_rst;
    logic [7:0]  low_len;
    logic [7:0]  high_len;

    // Cycle counters since reset and per RAS level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            low_len   <= '0;
            high_len  <= 8'hff;
        end else begin
            if (since_rst != 32'hffff_ffff) since_rst <= since_rst + 1'b1;
            low_len  <= ras_n ? 8'd0 : ((low_len == 8'hff) ? low_len : low_len + 1'b1);
            high_len <= !ras_n ? 8'd0 : ((high_len == 8'hff) ? high_len : high_len + 1'b1);
        end
    end

    // R10
    strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n || strobe_en) |-> bus_gnt);

    // R2
    no_req_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (since_rst >= 32'(PAUSE_CYC)));

    // R4
    init_done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R5
    cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R5
    cas_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R6
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_len >= 8'(RAS_CYC)));

    // R6
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_len >= 8'(PRE_CYC)));

endmodule

bind dram_refresh_sched drs_checker #(
    .PAUSE_CYC(PAUSE_CYC),
    .RAS_CYC  (C_RAS),
    .PRE_CYC  (C_PRE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_gnt  (bus_gnt),
    .bus_req  (bus_req),
    .strobe_en(strobe_en),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .init_done(init_done)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] interval_cycles = 16'd300;
    logic        gnt_en = 1'b1;
    logic        bus_gnt;
    logic        bus_req, strobe_en, ras_n, cas_n, we_n, init_done;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    int falls = 0;
    int v_grant = 0, v_we = 0, v_order = 0, v_width = 0, v_pre = 0, v_rc = 0;
    int low_len = 0, high_len = 100, cas_len = 0, since_fall = 100;
    logic prev_ras = 1'b1;

    always #10 clk = ~clk;

    assign bus_gnt = gnt_en & bus_req;

    dram_refresh_sched u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .interval_cycles(interval_cycles),
        .bus_gnt(bus_gnt), .bus_req(bus_req), .strobe_en(strobe_en),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done)
    );

    // Strobe monitor at the falling edge, counting protocol violations.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((!ras_n || !cas_n || strobe_en) && !bus_gnt) v_grant++;
            if (!we_n) v_we++;
            if (!ras_n && cas_n) v_order++;
            if (prev_ras && !ras_n) begin
                falls++;
                if (cas_len < 1) v_order++;
                if (high_len < 2) v_pre++;
                if (since_fall < 5) v_rc++;
                since_fall = 0;
            end
            if (!prev_ras && ras_n && low_len < 3) v_width++;
            if (!ras_n) begin low_len++; high_len = 0; end
            else begin high_len++; low_len = 0; end
            if (!cas_n) cas_len++; else cas_len = 0;
            since_fall++;
            prev_ras = ras_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // R1: outputs under reset and on the first cycle after release.
    task automatic t_reset_state;
        repeat (5) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!bus_req && !strobe_en && !init_done, "R1 req/en/done low in reset",
            {bus_req, strobe_en, init_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !bus_req && !init_done, "R1 idle after release",
            {ras_n, cas_n, bus_req, init_done}, 12);
    endtask

    // R2: pause length before the first bus request.
    task automatic t_pause;
        int n = 1;
        while (!bus_req && n < 20000) begin @(negedge clk); n++; end
        chk(n >= 5000 && n <= 5005, "R2 pause cycles before bus_req", n, 5001);
        chk(falls == 0, "R2 no RAS fall during pause", falls, 0);
    endtask

    // R3, R4: eight wake-up cycles, then init_done.
    task automatic t_init;
        int n = 0;
        bit seen8 = 0;
        int done_at8 = 1;
        while (!init_done && n < 2000) begin
            @(negedge clk); n++;
            if (falls == 8 && !seen8) begin seen8 = 1; done_at8 = init_done; end
        end
        chk(falls == 8, "R3 wake-up cycles before init_done", falls, 8);
        chk(n < 120, "R3 wake-up cycles back to back", n, 80);
        chk(seen8 && done_at8 == 0, "R4 init_done low at last wake-up RAS fall", done_at8, 0);
        chk(init_done == 1, "R4 init_done rises", init_done, 1);
    endtask

    // R7: one refresh per interval with immediate grant.
    task automatic t_interval;
        falls = 0;
        repeat (3000) @(negedge clk);
        chk(falls >= 9 && falls <= 11, "R7 refreshes in 3000 cycles at interval 300", falls, 10);
        chk(init_done == 1, "R4 init_done stays high", init_done, 1);
    endtask

    // Wait until no request is outstanding.
    task automatic wait_idle;
        int n = 0;
        while (bus_req && n < 1000) begin @(negedge clk); n++; end
    endtask

    // R8, R9: withheld grant long enough to saturate the backlog.
    task automatic t_backlog_sat;
        wait_idle();
        gnt_en = 1'b0;
        falls = 0;
        repeat (1800) @(negedge clk);
        chk(falls == 0, "R10 no RAS fall without grant", falls, 0);
        chk(bus_req == 1, "R8 request held while waiting", bus_req, 1);
        gnt_en = 1'b1;
        repeat (60) @(negedge clk);
        chk(falls >= 4 && falls <= 5, "R9 burst limited to backlog depth", falls, 4);
    endtask

    // R8: short withheld grant, all owed refreshes issued.
    task automatic t_backlog_small;
        repeat (400) @(negedge clk);
        wait_idle();
        gnt_en = 1'b0;
        falls = 0;
        repeat (600) @(negedge clk);
        gnt_en = 1'b1;
        repeat (40) @(negedge clk);
        chk(falls >= 2 && falls <= 4, "R8 owed refreshes issued after grant", falls, 2);
    endtask

    // R11, R7: interval equal to the cycle length, expiry meets completion.
    task automatic t_coincide;
        interval_cycles = 16'd10;
        repeat (400) @(negedge clk);
        falls = 0;
        repeat (1000) @(negedge clk);
        chk(falls >= 99 && falls <= 101, "R11 rate with coinciding tick and completion", falls, 100);
    endtask

    // R5, R6, R10: protocol counters over the whole run.
    task automatic t_protocol;
        chk(v_order == 0, "R5 CAS before RAS ordering", v_order, 0);
        chk(v_we == 0, "R5 we_n held high", v_we, 0);
        chk(v_width == 0, "R6 RAS low width", v_width, 0);
        chk(v_pre == 0, "R6 RAS precharge", v_pre, 0);
        chk(v_rc == 0, "R6 RAS fall spacing", v_rc, 0);
        chk(v_grant == 0, "R10 strobes only while granted", v_grant, 0);
    endtask

    initial begin
        t_reset_state();
        t_pause();
        t_init();
        t_interval();
        t_backlog_sat();
        t_backlog_small();
        t_coincide();
        t_protocol();
        finished = 1;
        summary();
        $finish;
    end

    // Watchdog ending a hung run as a failure.
    initial begin
        #(20 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL timeout on all requirements actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule